// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block keeps the interrupt state of an I2C master controller. The controller core sends single-cycle event pulses. Each pulse sets a bit in a raw status register. An enable register with the same bit layout selects which pending bits drive the single interrupt line. Software clears a status bit by writing a one to it. The bus-busy position is different: it shows the live busy level from the core and is not a latched event.

A second, older way to service interrupts is a vector register. It reports one pending and enabled event as a small code. Reading it clears the event it reported, so software can drain events one at a time with reads only.

All registers sit behind a plain 16-bit read/write port. Each access is a single cycle: `reg_en_i` qualifies it and `reg_wr_i` picks the direction. Read data is combinational from the current register state. The port has no handshake and never stalls.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, the status register reads 0x0000, the enable register reads 0x0000, the vector register reads 0 and `irq_o` is low.
- R2: A one on an event-capable position of `evt_i` sets that status bit on the next clock edge. The event-capable positions form the mask 0x6F1F:
  - bits 0 to 4: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready;
  - bits 8 to 11: address zero, addressed as slave, transmit underflow, receive overrun;
  - bits 13 and 14: receive drain, transmit drain.
  Pulses on any other position have no effect.
- R3: Writing the status register (address 0) clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: Status bit 12 shows `bus_busy_i` as sampled at the previous clock edge. Writes to status bit 12 have no effect on it.
- R6: The enable register (address 1) can be written and read back. Only the positions in mask 0x6F1F hold a value; all other positions read 0.
- R7: `irq_o` is high in the cycle after the AND of status and enable is non-zero, and low otherwise. When enable is 0x0000, `irq_o` stays low while status bits still latch events.
- R8: The vector register (address 2) reads a code in bits 2:0, with all other bits 0. The code is the lowest-numbered status bit among bits 0 to 4 that is both set and enabled, plus one: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. It reads 0 when none of these bits is both set and enabled.
- R9: A read of the vector register that returns a non-zero code clears the matching status bit at the end of the read cycle. All other bits are untouched, and a same-cycle event pulse on that bit wins.
- R10: Writes to address 2 have no effect, and address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | Single-cycle event pulses from the controller core, in status bit positions |
| bus_busy_i | input | 1 | Live bus-busy level from the controller core |
| reg_en_i | input | 1 | Register access in this cycle |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 reserved |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit registers, event mask 0x6F1F, busy at bit 12, and five vector sources with a 3-bit code. This puts every event position, the busy position and every vector code 0 to 5 within reach.

Directed steps cover:
- the pulse/clear race on one bit;
- vector drains with several sources pending at once;
- ignored writes to busy and to the vector address.

A long random run then overlaps event pulses with status clears and vector reads. A behavioural model predicts each read value and the interrupt level every cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 2;
  localparam int VEC_SRC_N = 5;
  localparam int CODE_W    = $clog2(VEC_SRC_N + 1);
  localparam int BUSY_BIT  = 12;
  localparam logic [REG_W-1:0] EVT_MASK = 16'h6F1F;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    MASK     = 16'h6F1F,
  parameter int              BUSY_POS = 12
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] evt_i,
  input  logic         busy_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  // Inputs on positions that hold no event are tied off here.
  logic unused_bits;
  assign unused_bits = ^(evt_i & ~MASK) ^ ^(clr_i & ~MASK);

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (MASK[k]) begin : g_evt
      logic bit_q;
      // Set has priority over clear, so a same-cycle event is kept.
      always_ff @(posedge clk_i) begin
        if (!rst_n_i)      bit_q <= 1'b0;
        else if (evt_i[k]) bit_q <= 1'b1;
        else if (clr_i[k]) bit_q <= 1'b0;
      end
      assign status_o[k] = bit_q;
    end else if (k == BUSY_POS) begin : g_busy
      logic busy_q;
      always_ff @(posedge clk_i) begin
        if (!rst_n_i) busy_q <= 1'b0;
        else          busy_q <= busy_i;
      end
      assign status_o[k] = busy_q;
    end else begin : g_none
      assign status_o[k] = 1'b0;
    end
  end

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(evt_i & MASK)) |=> ((status_o & $past(evt_i & MASK)) == $past(evt_i & MASK))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(clr_i & ~evt_i & MASK)) |=> ((status_o & $past(clr_i & ~evt_i & MASK)) == '0)); // R3

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(clr_i & evt_i & MASK)) |=> ((status_o & $past(clr_i & evt_i & MASK)) == $past(clr_i & evt_i & MASK))); // R4

  AST_BUSY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> (status_o[BUSY_POS] == $past(busy_i))); // R5
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = 16'h6F1F
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_n_i)  en_o <= '0;
    else if (wr_i) en_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  onehot_o
);
  // Scan from the top down so the lowest pending source is the last to win.
  always_comb begin
    code_o   = '0;
    onehot_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        code_o      = CW'(k + 1);
        onehot_o    = '0;
        onehot_o[k] = 1'b1;
      end
    end
  end

  AST_VEC_ONEHOT: assert final ($onehot0(onehot_o)); // R8
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              bus_busy_i,
  input  logic              reg_en_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0]     status_w;
  logic [REG_W-1:0]     enable_w;
  logic [REG_W-1:0]     pend_w;
  logic [REG_W-1:0]     clr_w;
  logic [REG_W-1:0]     vec_clr_w;
  logic [CODE_W-1:0]    vec_code_w;
  logic [VEC_SRC_N-1:0] vec_oh_w;
  logic                 wr_stat_w, wr_en_w, rd_vec_w;
  reg_sel_e             sel_w;

  assign sel_w     = reg_sel_e'(reg_addr_i);
  assign wr_stat_w = reg_en_i &  reg_wr_i & (sel_w == SEL_STATUS);
  assign wr_en_w   = reg_en_i &  reg_wr_i & (sel_w == SEL_ENABLE);
  assign rd_vec_w  = reg_en_i & ~reg_wr_i & (sel_w == SEL_VECTOR);

  assign pend_w    = status_w & enable_w;
  assign vec_clr_w = rd_vec_w ? {{(REG_W-VEC_SRC_N){1'b0}}, vec_oh_w} : '0;
  assign clr_w     = (wr_stat_w ? reg_wdata_i : '0) | vec_clr_w;

  irq_status_bank #(.W(REG_W), .MASK(EVT_MASK), .BUSY_POS(BUSY_BIT)) u_status (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .evt_i    (evt_i),
    .busy_i   (bus_busy_i),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  irq_enable_reg #(.W(REG_W), .MASK(EVT_MASK)) u_enable (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .wr_i    (wr_en_w),
    .wdata_i (reg_wdata_i),
    .en_o    (enable_w)
  );

  irq_vector_enc #(.N(VEC_SRC_N), .CW(CODE_W)) u_vector (
    .pend_i   (pend_w[VEC_SRC_N-1:0]),
    .code_o   (vec_code_w),
    .onehot_o (vec_oh_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) irq_o <= 1'b0;
    else          irq_o <= |pend_w;
  end

  always_comb begin
    unique case (sel_w)
      SEL_STATUS: reg_rdata_o = status_w;
      SEL_ENABLE: reg_rdata_o = enable_w;
      SEL_VECTOR: reg_rdata_o = {{(REG_W-CODE_W){1'b0}}, vec_code_w};
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (enable_w == '0) |=> !irq_o); // R7

  AST_VEC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rd_vec_w |=> ((status_w & $past(vec_clr_w & ~evt_i)) == '0)); // R9

  AST_BUSY_NOT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_en_w |=> !enable_w[BUSY_BIT]); // R6
endmodule

// File: tb/i2c_irq_unit_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_unit_tb_top;
  localparam logic [15:0] MASK = 16'h6F1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        busy = 1'b0;
  logic        en = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;

  // Behavioural model state.
  logic [15:0] m_stat = '0;
  logic [15:0] m_en = '0;
  logic        m_busy = 1'b0;
  logic        m_irq = 1'b0;

  always #5 clk = ~clk;

  i2c_irq_unit dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .bus_busy_i(busy),
    .reg_en_i(en), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int m_code();
    logic [15:0] p;
    p = m_stat & m_en;
    for (int k = 0; k < 5; k++) if (p[k]) return k + 1;
    return 0;
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return (m_stat & MASK) | (16'(m_busy) << 12);
      2'd1:    return m_en;
      2'd2:    return 16'(m_code());
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic e, input logic w, input logic [1:0] a,
                     input logic [15:0] d, input logic [15:0] ev,
                     input logic b, input string tag);
    int          code;
    logic [15:0] clr;
    logic        irq_n;
    @(negedge clk);
    en = e; wr = w; addr = a; wdata = d; evt = ev; busy = b;
    #1;
    check("R7 irq", {15'b0, irq}, {15'b0, m_irq});
    if (e && !w) check(tag, rdata, m_read(a));
    code  = m_code();
    clr   = (e && w && a == 2'd0) ? d : 16'h0000;
    if (e && !w && a == 2'd2 && code != 0) clr[code-1] = 1'b1;
    irq_n = |(m_stat & m_en);
    @(posedge clk);
    #1;
    m_stat = ((m_stat & ~clr) | ev) & MASK;
    if (e && w && a == 2'd1) m_en = d & MASK;
    m_busy = b;
    m_irq  = irq_n;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 16'h0, 16'h0, busy, tag);
  endtask
  task automatic wrr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 16'h0, busy, tag);
  endtask
  task automatic pulse(input logic [15:0] ev, input string tag);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, ev, busy, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, "R1 status");
    rd(2'd1, "R1 enable");
    rd(2'd2, "R1 vector");
    // R6 enable write/readback
    wrr(2'd1, 16'hFFFF, "R6");
    rd(2'd1, "R6 readback");
    wrr(2'd1, 16'h0000, "R6");
    // R2 events latch while masked, irq low (R7)
    pulse(16'hFFFF, "R2");
    rd(2'd0, "R2 all events");
    pulse(16'h0000, "R7");
    rd(2'd0, "R7 masked");
    // R3 write one to clear, write zero keeps
    wrr(2'd0, 16'h0003, "R3");
    rd(2'd0, "R3 cleared");
    wrr(2'd0, 16'h0000, "R3");
    rd(2'd0, "R3 zero write");
    // R4 event wins over clear
    cyc(1'b1, 1'b1, 2'd0, 16'h0004, 16'h0004, 1'b0, "R4");
    rd(2'd0, "R4 kept");
    // R5 busy follows input and ignores clears
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 1'b1, "R5");
    rd(2'd0, "R5 busy set");
    wrr(2'd0, 16'h1000, "R5");
    rd(2'd0, "R5 busy kept");
    busy = 1'b0;
    pulse(16'h0000, "R5");
    rd(2'd0, "R5 busy clear");
    // R7 interrupt raise
    wrr(2'd1, 16'h0004, "R7");
    pulse(16'h0000, "R7");
    pulse(16'h0000, "R7");
    // R8/R9 vector drain
    pulse(16'h001F, "R8");
    wrr(2'd1, 16'h001F, "R8");
    for (int i = 0; i < 7; i++) rd(2'd2, "R8 R9 vector drain");
    rd(2'd0, "R9 status after drain");
    // R9 same-cycle event on the reported bit wins
    pulse(16'h0002, "R9");
    cyc(1'b1, 1'b0, 2'd2, 16'h0, 16'h0002, 1'b0, "R9 race");
    rd(2'd2, "R9 race kept");
    // R10 vector writes ignored, reserved reads zero
    wrr(2'd2, 16'hFFFF, "R10");
    rd(2'd2, "R10 vector");
    rd(2'd0, "R10 status");
    rd(2'd3, "R10 reserved");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ev;
      logic [1:0]  a;
      ev = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      a  = 2'($urandom_range(0, 3));
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, a,
          16'($urandom), ev, $urandom_range(0, 1) == 1, "R2 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule